// File: doc/BRIEF.md
# Early-Exit Vector Length Truncation Unit

This unit sits beside a vector element loop and watches the per-element outcomes as they arrive, in strict order from element 0. It decides whether each element's result may be written, whether the loop ends early, and what the vector length becomes after that early end. A `start` pulse loads the requested length and the mode settings. After that, one element is evaluated on every cycle in which `elem_valid` is high. The unit reports the end of the loop with a one-cycle `done` pulse. The resulting length stays on `vl_out` until the next start.

There are two modes. In condition mode, one bit of each element's 4-bit condition field is chosen by `bit_sel` and compared with `invert`. The first element whose bit equals `invert` ends the loop, and an inclusive option decides whether that element is counted and written. A compare-only option suppresses every result write and keeps the condition-field writes. In memory mode, the unit follows per-element exception flags. An exception on element 0 is raised as a normal fault. An exception on any later element raises nothing and cuts the length back to that element's index. A hardware truncation request works the same way as a later exception.

Top module: `ffvl_trunc`

## Requirements
- R1: After reset, `vl_out` is 0 and `busy`, `done`, `res_we`, `cr_we` and `exc_raise` are all 0.
- R2: `start` loads the length `vl_in`, clamped to MAX_VL (default 64). If the loaded length is 0, `done` pulses in the next cycle with `vl_out` = 0 and no element is accepted.
- R3: In condition mode (`ldst_mode`=0), `bit_sel` values 0, 1, 2 and 3 select condition bits 3 (LT), 2 (GT), 1 (EQ) and 0 (SO) of `elem_cr`. An element fails when the selected bit equals `invert`. The unselected bits have no effect.
- R4: When element i is the first to fail, the loop stops and `done` pulses in the following cycle. `vl_out` becomes i+1 if the effective inclusive flag is set and i otherwise, so a failure on element 0 without the inclusive flag gives 0.
- R5: The effective inclusive flag is `inclusive` AND NOT `rec_cond`. With `rec_cond`=1, `inclusive` has no effect.
- R6: In condition mode, `cr_we` is 1 for every evaluated element. `res_we` is 1 for passing elements, and for the failing element only when the effective inclusive flag is set. With `cmp_only`=1, `res_we` stays 0 for every element.
- R7: If no element fails or truncates, `vl_out` keeps the loaded length and `done` pulses in the cycle after the element with index length-1 is accepted.
- R8: In memory mode (`ldst_mode`=1), an exception on element 0 drives `exc_raise`=1 in that element's cycle with `res_we`=0. The loop stops and `vl_out` keeps the loaded length.
- R9: In memory mode, an exception on element i ≥ 1 drives `exc_raise`=0 and `res_we`=0, stops the loop, and sets `vl_out` to i.
- R10: `hw_trunc` on a memory-mode element i ≥ 1 stops the loop with `vl_out` = i and `res_we`=0. It is ignored on element 0 and in condition mode.
- R11: While no loop runs, `elem_valid` has no effect: `res_we`, `cr_we` and `exc_raise` stay 0, and `vl_out` holds its value until the next `start`.
- R12: A cycle with `elem_valid`=0 during a loop evaluates nothing and does not advance the element index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new loop; latches length and settings |
| vl_in | input | VLW | Requested vector length |
| ldst_mode | input | 1 | 0 = condition mode, 1 = memory mode |
| bit_sel | input | 2 | Condition bit selector |
| invert | input | 1 | Value of the selected bit that counts as failure |
| inclusive | input | 1 | Count and write the failing element |
| rec_cond | input | 1 | Record-condition option; disables `inclusive` |
| cmp_only | input | 1 | Suppress all result writes in condition mode |
| elem_valid | input | 1 | An element outcome is presented this cycle |
| elem_cr | input | 4 | Condition field of the element (3=LT,2=GT,1=EQ,0=SO) |
| elem_exc | input | 1 | Element would raise a memory exception |
| hw_trunc | input | 1 | Hardware-chosen truncation request (memory mode) |
| vl_out | output | VLW | Resulting vector length |
| busy | output | 1 | A loop is running |
| done | output | 1 | One-cycle pulse when the loop has ended |
| res_we | output | 1 | Result write enable for the presented element |
| cr_we | output | 1 | Condition-field write enable for the presented element |
| exc_raise | output | 1 | Raise the element's exception |

## Verification
Two events can fall in the same cycle. The first is a failing or truncating element that is also the element with index length-1, so the normal end and the early exit meet on one edge. The bench makes this happen by placing the failure on the last element, with and without the inclusive flag. It checks that `done` pulses once and that `vl_out` takes the truncated value, not the loaded one. The second is a memory-mode element 0 that carries both an exception and a truncation request. The bench checks that the fault is raised, that `vl_out` keeps the loaded length, and that the request is not applied.

// File: rtl/ffvl_pkg.sv
package ffvl_pkg;
   localparam int FF_CR_W  = 4;
   localparam int FF_SEL_W = $clog2(FF_CR_W);

   typedef enum logic {
      FF_COND = 1'b0,
      FF_LDST = 1'b1
   } ff_mode_e;

   typedef struct packed {
      ff_mode_e              mode;
      logic [FF_SEL_W-1:0]   sel;
      logic                  inv;
      logic                  incl_eff;
      logic                  cmp_only;
   } ff_cfg_t;
endpackage

// File: rtl/ffvl_cond_eval.sv
module ffvl_cond_eval
   import ffvl_pkg::*;
#(
   parameter int CR_W         = FF_CR_W,
   parameter int SEL_W        = FF_SEL_W,
   parameter bit SEL_MSB_FIRST = 1'b1
) (
   input  logic            go,
   input  ff_cfg_t         cfg,
   input  logic [CR_W-1:0] cr,
   output logic            fail,
   output logic            write_ok,
   output logic            cr_write
);
   localparam int unsigned TOP_BIT = CR_W - 1;

   if (CR_W < 2 || (1 << SEL_W) != CR_W) begin : g_bad_width
      $error("ffvl_cond_eval: CR_W must be a power of two matching SEL_W");
   end

   logic [SEL_W-1:0] bit_idx;
   logic             tested;
   logic             act;

   if (SEL_MSB_FIRST) begin : g_msb_first
      assign bit_idx = SEL_W'(TOP_BIT) - cfg.sel;
   end else begin : g_lsb_first
      assign bit_idx = cfg.sel;
   end

   assign tested   = cr[bit_idx];
   assign act      = go && (cfg.mode == FF_COND);
   assign fail     = act && (tested == cfg.inv);
   assign cr_write = act;
   assign write_ok = act && !cfg.cmp_only && (!fail || cfg.incl_eff);
endmodule

// File: rtl/ffvl_ldst_eval.sv
module ffvl_ldst_eval
   import ffvl_pkg::*;
#(
   parameter bit HW_TRUNC_EN = 1'b1
) (
   input  logic go,
   input  ff_cfg_t cfg,
   input  logic first,
   input  logic exc,
   input  logic trq,
   output logic raise,
   output logic late_stop,
   output logic write_ok
);
   logic trq_h;
   logic act;

   if (HW_TRUNC_EN) begin : g_trunc_on
      assign trq_h = trq;
   end else begin : g_trunc_off
      logic unused_trq;
      assign unused_trq = trq;
      assign trq_h      = 1'b0;
   end

   assign act       = go && (cfg.mode == FF_LDST);
   assign raise     = act && first && exc;
   assign late_stop = act && !first && (exc || trq_h);
   assign write_ok  = act && !raise && !late_stop;
endmodule

// File: rtl/ffvl_ctrl.sv
module ffvl_ctrl
   import ffvl_pkg::*;
#(
   parameter int MAX_VL = 64,
   parameter int VLW    = $clog2(MAX_VL + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [VLW-1:0] vl_in,
   input  ff_cfg_t        cfg_in,
   input  logic           step,
   input  logic           halt,
   input  logic [VLW-1:0] new_vl,
   output ff_cfg_t        cfg,
   output logic [VLW-1:0] idx,
   output logic [VLW-1:0] vl_out,
   output logic           busy,
   output logic           done
);
   localparam logic [VLW-1:0] VL_CAP = VLW'(MAX_VL);

   if (MAX_VL < 1) begin : g_bad_max
      $error("ffvl_ctrl: MAX_VL must be at least 1");
   end

   logic [VLW-1:0] vl_load;
   logic [VLW-1:0] vl_orig;
   logic           at_last;

   assign vl_load = (vl_in > VL_CAP) ? VL_CAP : vl_in;
   assign at_last = (idx == vl_out - VLW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg     <= '0;
         idx     <= '0;
         vl_out  <= '0;
         vl_orig <= '0;
         busy    <= 1'b0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            cfg     <= cfg_in;
            idx     <= '0;
            vl_out  <= vl_load;
            vl_orig <= vl_load;
            busy    <= (vl_load != '0);
            done    <= (vl_load == '0);
         end else if (busy && step) begin
            if (halt) begin
               vl_out <= new_vl;
               busy   <= 1'b0;
               done   <= 1'b1;
            end else if (at_last) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               idx <= idx + VLW'(1);
            end
         end
      end
   end

   assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   assert_vl_no_grow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (vl_out <= vl_orig));
   assert_gap_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !step && !start) |=> $stable(idx) && busy);
endmodule

// File: rtl/ffvl_trunc.sv
module ffvl_trunc
   import ffvl_pkg::*;
#(
   parameter int MAX_VL        = 64,
   parameter int VLW           = $clog2(MAX_VL + 1),
   parameter bit HW_TRUNC_EN   = 1'b1,
   parameter bit SEL_MSB_FIRST = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [VLW-1:0]      vl_in,
   input  logic                ldst_mode,
   input  logic [FF_SEL_W-1:0] bit_sel,
   input  logic                invert,
   input  logic                inclusive,
   input  logic                rec_cond,
   input  logic                cmp_only,
   input  logic                elem_valid,
   input  logic [FF_CR_W-1:0]  elem_cr,
   input  logic                elem_exc,
   input  logic                hw_trunc,
   output logic [VLW-1:0]      vl_out,
   output logic                busy,
   output logic                done,
   output logic                res_we,
   output logic                cr_we,
   output logic                exc_raise
);
   if (VLW < $clog2(MAX_VL + 1)) begin : g_bad_vlw
      $error("ffvl_trunc: VLW too narrow for MAX_VL");
   end

   ff_cfg_t        cfg_in, cfg;
   logic [VLW-1:0] idx, new_vl;
   logic           go, first, halt;
   logic           c_fail, c_wr, c_crw;
   logic           m_raise, m_late, m_wr;

   assign cfg_in.mode     = ldst_mode ? FF_LDST : FF_COND;
   assign cfg_in.sel      = bit_sel;
   assign cfg_in.inv      = invert;
   assign cfg_in.incl_eff = inclusive && !rec_cond;
   assign cfg_in.cmp_only = cmp_only;

   assign go    = busy && elem_valid && !start;
   assign first = (idx == '0);

   ffvl_cond_eval #(
      .CR_W(FF_CR_W), .SEL_W(FF_SEL_W), .SEL_MSB_FIRST(SEL_MSB_FIRST)
   ) u_cond (
      .go(go), .cfg(cfg), .cr(elem_cr),
      .fail(c_fail), .write_ok(c_wr), .cr_write(c_crw)
   );

   ffvl_ldst_eval #(.HW_TRUNC_EN(HW_TRUNC_EN)) u_ldst (
      .go(go), .cfg(cfg), .first(first), .exc(elem_exc), .trq(hw_trunc),
      .raise(m_raise), .late_stop(m_late), .write_ok(m_wr)
   );

   assign halt   = c_fail || m_raise || m_late;
   assign new_vl = c_fail  ? (idx + VLW'(cfg.incl_eff)) :
                   m_raise ? vl_out : idx;

   ffvl_ctrl #(.MAX_VL(MAX_VL), .VLW(VLW)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .vl_in(vl_in),
      .cfg_in(cfg_in), .step(go), .halt(halt), .new_vl(new_vl),
      .cfg(cfg), .idx(idx), .vl_out(vl_out), .busy(busy), .done(done)
   );

   assign res_we    = c_wr || m_wr;
   assign cr_we     = c_crw;
   assign exc_raise = m_raise;

   assert_cmp_nowrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cfg.mode == FF_COND && cfg.cmp_only) |-> !res_we);
   assert_fail_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (c_fail && !start) |=> done && (vl_out == $past(idx) + VLW'($past(cfg.incl_eff))));
   assert_first_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_raise && !start) |=> done && (vl_out == $past(vl_out)));
   assert_late_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (go && cfg.mode == FF_LDST && !first && elem_exc) |-> !exc_raise && !res_we);
   assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(vl_out));
   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !res_we && !cr_we && !exc_raise);
endmodule

// File: tb/ffvl_trunc_tb.sv
module ffvl_trunc_tb;
   localparam int CLK_PERIOD = 10;
   localparam int MAX_VL     = 64;
   localparam int VLW        = $clog2(MAX_VL + 1);

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic [VLW-1:0] vl_in = '0;
   logic           ldst_mode = 1'b0;
   logic [1:0]     bit_sel = '0;
   logic           invert = 1'b0, inclusive = 1'b0, rec_cond = 1'b0, cmp_only = 1'b0;
   logic           elem_valid = 1'b0;
   logic [3:0]     elem_cr = '0;
   logic           elem_exc = 1'b0, hw_trunc = 1'b0;
   logic [VLW-1:0] vl_out;
   logic           busy, done, res_we, cr_we, exc_raise;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   logic [3:0] t_cr  [0:MAX_VL-1];
   logic       t_exc [0:MAX_VL-1];
   logic       t_trq [0:MAX_VL-1];

   ffvl_trunc #(.MAX_VL(MAX_VL)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .vl_in(vl_in),
      .ldst_mode(ldst_mode), .bit_sel(bit_sel), .invert(invert),
      .inclusive(inclusive), .rec_cond(rec_cond), .cmp_only(cmp_only),
      .elem_valid(elem_valid), .elem_cr(elem_cr), .elem_exc(elem_exc),
      .hw_trunc(hw_trunc), .vl_out(vl_out), .busy(busy), .done(done),
      .res_we(res_we), .cr_we(cr_we), .exc_raise(exc_raise)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string tag, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic bit cond_fails(input logic [3:0] cr, input int sel, input bit inv);
      return cr[3 - sel] == inv;
   endfunction

   task automatic clear_vec();
      for (int i = 0; i < MAX_VL; i++) begin
         t_cr[i] = 4'h0; t_exc[i] = 1'b0; t_trq[i] = 1'b0;
      end
   endtask

   // Runs one loop; the final-length check is tagged with ftag.
   task automatic run_vec(input int vl, input bit ld, input int sel, input bit inv,
                          input bit incl, input bit rec, input bit cmp,
                          input bit gaps, input string ftag);
      int  eff  = (vl > MAX_VL) ? MAX_VL : vl;
      bit  ie   = incl && !rec;
      int  evl  = eff;
      int  last = eff - 1;
      bit  e_we [0:MAX_VL-1];
      bit  e_rs [0:MAX_VL-1];
      for (int i = 0; i < eff; i++) begin
         bit stop = 1'b0;
         e_rs[i] = 1'b0;
         if (!ld) begin
            bit f = cond_fails(t_cr[i], sel, inv);
            e_we[i] = !cmp && (!f || ie);
            if (f) begin stop = 1'b1; evl = i + (ie ? 1 : 0); end
         end else if (i == 0) begin
            e_we[i] = !t_exc[i];
            if (t_exc[i]) begin stop = 1'b1; e_rs[i] = 1'b1; evl = eff; end
         end else begin
            e_we[i] = !(t_exc[i] || t_trq[i]);
            if (t_exc[i] || t_trq[i]) begin stop = 1'b1; evl = i; end
         end
         if (stop) begin last = i; break; end
      end
      @(negedge clk);
      start = 1'b1; vl_in = VLW'(vl); ldst_mode = ld; bit_sel = 2'(sel);
      invert = inv; inclusive = incl; rec_cond = rec; cmp_only = cmp;
      elem_valid = 1'b0;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i <= last; i++) begin
         if (gaps && ($urandom % 4 == 0)) begin
            elem_valid = 1'b0; elem_exc = 1'b1; hw_trunc = 1'b1; elem_cr = 4'hF;
            #1;
            chk("R12 gap res_we", res_we, 0);
            chk("R12 gap cr_we", cr_we, 0);
            @(negedge clk);
            chk("R12 gap no done", done, 0);
         end
         elem_valid = 1'b1; elem_cr = t_cr[i]; elem_exc = t_exc[i]; hw_trunc = t_trq[i];
         #1;
         chk(ld ? "R9 res_we" : "R6 res_we", res_we, e_we[i]);
         chk("R6 cr_we", cr_we, ld ? 0 : 1);
         chk(i == 0 ? "R8 exc_raise" : "R9 exc_raise", exc_raise, e_rs[i]);
         @(negedge clk);
         if (i < last) chk("R7 no early done", done, 0);
      end
      elem_valid = 1'b0; elem_exc = 1'b0; hw_trunc = 1'b0;
      chk({ftag, " done pulse"}, done, 1);
      chk({ftag, " vl_out"}, vl_out, evl);
      chk({ftag, " busy low"}, busy, 0);
      // idle stimulus must not act
      elem_valid = 1'b1; elem_exc = 1'b1; hw_trunc = 1'b1; elem_cr = t_cr[0] ^ 4'hF;
      #1;
      chk("R11 idle res_we", res_we, 0);
      chk("R11 idle exc_raise", exc_raise, 0);
      @(negedge clk);
      elem_valid = 1'b0; elem_exc = 1'b0; hw_trunc = 1'b0;
      chk("R11 done single", done, 0);
      chk("R11 vl held", vl_out, evl);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog R1 actual=running expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = $urandom(32'h5eed);
      #(CLK_PERIOD * 2 + 2);
      chk("R1 vl_out", vl_out, 0);
      chk("R1 busy", busy, 0);
      chk("R1 done", done, 0);
      chk("R1 res_we", res_we, 0);
      chk("R1 exc_raise", exc_raise, 0);
      rst_n = 1'b1;

      // R3: each selector; element 1 has every other bit at inv
      for (int s = 0; s < 4; s++) begin
         clear_vec();
         t_cr[1] = ~(4'b1 << (3 - s));
         t_cr[2] =  (4'b1 << (3 - s));
         run_vec(4, 0, s, 1, 0, 0, 0, 0, "R3");
      end
      // R4 / R5: fail on element 2
      clear_vec(); t_cr[2] = 4'b0010;
      run_vec(5, 0, 2, 1, 1, 0, 0, 0, "R4 inclusive");
      run_vec(5, 0, 2, 1, 1, 1, 0, 0, "R5 rec disables inclusive");
      run_vec(5, 0, 2, 1, 0, 0, 0, 0, "R4 exclusive");
      // R4: fail on element 0 gives zero
      clear_vec();
      run_vec(6, 0, 0, 0, 0, 0, 0, 0, "R4 zero length");
      // fail on last element, both inclusive settings
      clear_vec(); for (int i = 0; i < 4; i++) t_cr[i] = 4'hF; t_cr[3] = 4'h0;
      run_vec(4, 0, 1, 0, 1, 0, 0, 0, "R4 last inclusive");
      run_vec(4, 0, 1, 0, 0, 0, 0, 0, "R4 last exclusive");
      // R6 compare-only, R7 no failure, R2 clamp and zero
      clear_vec();
      run_vec(5, 0, 3, 1, 0, 0, 1, 0, "R6 cmp_only");
      run_vec(5, 0, 3, 1, 0, 0, 0, 0, "R7 full length");
      run_vec(100, 0, 3, 1, 0, 0, 0, 0, "R2 clamp");
      run_vec(0, 0, 3, 1, 0, 0, 0, 0, "R2 zero load");
      // R8 / R9 / R10
      clear_vec(); t_exc[0] = 1'b1; t_trq[0] = 1'b1;
      run_vec(6, 1, 0, 0, 0, 0, 0, 0, "R8 first fault");
      clear_vec(); t_exc[3] = 1'b1;
      run_vec(6, 1, 0, 0, 0, 0, 0, 0, "R9 late fault");
      clear_vec(); t_trq[0] = 1'b1; t_trq[2] = 1'b1;
      run_vec(6, 1, 0, 0, 0, 0, 0, 0, "R10 hw trunc");
      clear_vec(); for (int i = 0; i < 6; i++) t_trq[i] = 1'b1;
      run_vec(6, 0, 3, 1, 0, 0, 0, 0, "R10 cond ignores trunc");
      // R12 gaps
      clear_vec(); t_cr[4] = 4'b1000;
      run_vec(8, 0, 0, 1, 0, 0, 0, 1, "R12 gaps");

      // random mix
      for (int n = 0; n < 300; n++) begin
         int vl  = $urandom % 20;
         bit ld  = $urandom % 2;
         int sel = $urandom % 4;
         bit inv = $urandom % 2;
         for (int i = 0; i < MAX_VL; i++) begin
            logic [3:0] c = 4'($urandom);
            if ($urandom % 8 != 0) c[3 - sel] = ~inv;
            t_cr[i]  = c;
            t_exc[i] = ($urandom % 10 == 0);
            t_trq[i] = ($urandom % 16 == 0);
         end
         run_vec(vl, ld, sel, inv, $urandom % 2, $urandom % 2, $urandom % 4 == 0,
                 1, ld ? "R9 random" : "R4 random");
      end

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule